// File: doc/BRIEF.md
# Software Flow Control Receive Matcher

This block sits between a serial receiver and its receive FIFO. It inspects each received character and decides whether it is ordinary data or an in-band flow-control request from the far end. A "stop sending" sequence pauses the local transmitter. A "resume sending" sequence releases it. Characters used up by a match never reach the FIFO. Every other character is passed on through a single write-enable and data pair.

Matching runs in one of three modes. When off, every character is passed through. In single-character mode, one received character is compared against a stop code and a resume code. In pair mode, two consecutive characters must equal a programmed first/second pair, in order. While a pair is half-seen, its first character is held back. If the second character breaks the pair, both characters are released to the FIFO in order on consecutive cycles. The comparison covers only the configured character width (5 to 8 bits).

The pause is applied only on a character boundary reported by the transmitter, so a character already on the wire is never cut. A sticky flow flag records that the far end has asked for a pause. An interrupt request follows that flag when it is enabled.

Top module: `swFlowMatcher`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, txHold, fifoWrEn, flowFlag and irq are all low.
- R2: With cfgMode equal to 0 or 3 (off), every strobed character is presented on fifoWrData with fifoWrEn high exactly one clock after its rxValid cycle, unchanged, whatever its value.
- R3: With cfgMode equal to 1 (single), a character equal to cfgXoff1 is dropped and sets flowFlag one clock after its strobe. A character equal to cfgXon1 but not cfgXoff1 is dropped and releases the pause. Any other character is written one clock after its strobe.
- R4: With cfgMode equal to 2 (pair), the sequence cfgXoff1 then cfgXoff2 (or cfgXon1 then cfgXon2) on two consecutive strobes is dropped entirely, and the stop or resume action takes effect one clock after the second strobe.
- R5: In pair mode, if a held first character is followed by a character that does not complete its pair, the held character is written one clock after the second strobe and the second character one clock later.
- R6: After a stop match, txHold rises one clock after the strobe if txBoundary is high in the strobe cycle. Otherwise it rises one clock after the first later cycle in which txBoundary is high. txHold never rises without txBoundary high in the preceding cycle.
- R7: A resume match clears txHold, any pause still waiting for a boundary, and flowFlag one clock after its strobe.
- R8: irq is high exactly when flowFlag and cfgIntEn are both high.
- R9: Only the low 5+cfgWordLen bits of a character take part in matching (cfgWordLen 0..3 gives 5..8 bits). Data written to the FIFO keeps all 8 bits.
- R10: A change of cfgMode abandons a half-seen pair. The held first character is discarded and never written.
- R11: In pair mode, a first character that equals both cfgXoff1 and cfgXon1 is resolved by the second character. The stop pair is tested before the resume pair.
- R12: Selecting an off mode clears txHold and any waiting pause one clock later. flowFlag is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | One-cycle strobe for a received character; strobes are separated by at least one idle cycle |
| rxData | input | 8 | Received character |
| cfgMode | input | 2 | 0/3 off, 1 single-character, 2 pair |
| cfgWordLen | input | 2 | Compared bits = 5 + value |
| cfgXon1 | input | 8 | Resume code (single mode) or first resume character (pair mode) |
| cfgXon2 | input | 8 | Second resume character |
| cfgXoff1 | input | 8 | Stop code (single mode) or first stop character (pair mode) |
| cfgXoff2 | input | 8 | Second stop character |
| cfgIntEn | input | 1 | Interrupt enable for the flow flag |
| txBoundary | input | 1 | Transmitter is between characters |
| txHold | output | 1 | Transmitter must not start a new character |
| fifoWrEn | output | 1 | Write strobe toward the receive FIFO |
| fifoWrData | output | 8 | Character to write |
| flowFlag | output | 1 | Set by a stop match, cleared by a resume match |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are timing-dependent. One is a stop match that arrives while the transmitter is mid-character, followed by a resume or a mode change before any boundary. The other is a broken pair whose two-cycle release runs into a reconfiguration. Directed sequences hold txBoundary low across a stop match, then raise it, resume, or switch off at chosen points. A long random phase mixes the four control codes with arbitrary bytes, moves txBoundary, cfgIntEn, the mode and the word length between strobes, and compares every output each clock against a queue-based reference model.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_SINGLE  = 2'd1,
    MODE_PAIR    = 2'd2,
    MODE_OFF_ALT = 2'd3
  } fcMode_e;

  // Slots of the reference-character vector fed to the comparators
  localparam int IDX_XOFF1 = 0;
  localparam int IDX_XOFF2 = 1;
  localparam int IDX_XON1  = 2;
  localparam int IDX_XON2  = 3;
  localparam int NUM_REF   = 4;

  // Strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic wrCur;          // write the incoming character
    logic wrHeldThenCur;  // broken pair: write held now, incoming next cycle
    logic captureHeld;    // hold the incoming character as a pair candidate
    logic xoffHit;        // stop sequence completed
    logic xonHit;         // resume sequence completed
    logic flowOff;        // matching disabled this cycle
  } fcStrobe_t;

endpackage

// File: rtl/swfc_cmp.sv
module swfc_cmp #(
  parameter int CHAR_W  = 8,
  parameter int NUM_REF = 4,
  parameter int LEN_W   = 2
) (
  input  logic [CHAR_W-1:0]              rxData,
  input  logic [NUM_REF-1:0][CHAR_W-1:0] refChars,
  input  logic [LEN_W-1:0]               wordLen,
  output logic [NUM_REF-1:0]             hit
);

  // Shortest compared width: the widest setting equals CHAR_W
  localparam int MIN_BITS = CHAR_W - (1 << LEN_W) + 1;

  logic [CHAR_W-1:0] cmpMask;

  always_comb begin
    for (int i = 0; i < CHAR_W; i++) begin
      cmpMask[i] = (i < (MIN_BITS + int'(wordLen)));
    end
  end

  for (genvar g = 0; g < NUM_REF; g++) begin : gRef
    assign hit[g] = ((rxData ^ refChars[g]) & cmpMask) == '0;
  end

endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl
  import swfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [1:0] cfgMode,
  input  logic       hitXoff1,
  input  logic       hitXoff2,
  input  logic       hitXon1,
  input  logic       hitXon2,
  output fcStrobe_t  strobe
);

  fcMode_e mode;
  fcMode_e prevMode;
  logic    partXoff, partXon;
  logic    nextXoff, nextXon;
  logic    modeChanged;
  logic    curXoff, curXon;

  assign mode = fcMode_e'(cfgMode);

  always_comb begin
    modeChanged = (mode != prevMode);
    curXoff     = partXoff && !modeChanged;
    curXon      = partXon && !modeChanged;
    strobe      = '0;
    strobe.flowOff = (mode == MODE_OFF) || (mode == MODE_OFF_ALT);
    nextXoff    = curXoff;
    nextXon     = curXon;
    if (rxValid) begin
      case (mode)
        MODE_SINGLE: begin
          if (hitXoff1)     strobe.xoffHit = 1'b1;
          else if (hitXon1) strobe.xonHit  = 1'b1;
          else              strobe.wrCur   = 1'b1;
        end
        MODE_PAIR: begin
          if (curXoff || curXon) begin
            if (curXoff && hitXoff2)     strobe.xoffHit       = 1'b1;
            else if (curXon && hitXon2)  strobe.xonHit        = 1'b1;
            else                         strobe.wrHeldThenCur = 1'b1;
            nextXoff = 1'b0;
            nextXon  = 1'b0;
          end else if (hitXoff1 || hitXon1) begin
            strobe.captureHeld = 1'b1;
            nextXoff = hitXoff1;
            nextXon  = hitXon1;
          end else begin
            strobe.wrCur = 1'b1;
          end
        end
        default: strobe.wrCur = 1'b1;
      endcase
    end
    if (mode != MODE_PAIR) begin
      nextXoff = 1'b0;
      nextXon  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMode <= MODE_OFF;
      partXoff <= 1'b0;
      partXon  <= 1'b0;
    end else begin
      prevMode <= mode;
      partXoff <= nextXoff;
      partXon  <= nextXon;
    end
  end

  // A half-seen pair only survives while pair mode was selected
  assert_partial_pair_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    (partXoff || partXon) |-> ($past(cfgMode) == MODE_PAIR));

endmodule

// File: rtl/swfc_dp.sv
module swfc_dp
  import swfc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              txBoundary,
  input  logic              cfgIntEn,
  input  fcStrobe_t         strobe,
  output logic              txHold,
  output logic              fifoWrEn,
  output logic [CHAR_W-1:0] fifoWrData,
  output logic              flowFlag,
  output logic              irq
);

  logic [CHAR_W-1:0] heldChar;
  logic [CHAR_W-1:0] spillChar;
  logic              spillValid;
  logic              pausePending;

  // Data path toward the FIFO
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldChar   <= '0;
      spillChar  <= '0;
      spillValid <= 1'b0;
      fifoWrEn   <= 1'b0;
      fifoWrData <= '0;
    end else begin
      if (strobe.captureHeld) heldChar <= rxData;
      spillValid <= strobe.wrHeldThenCur;
      if (strobe.wrHeldThenCur) spillChar <= rxData;
      fifoWrEn <= spillValid || strobe.wrCur || strobe.wrHeldThenCur;
      if (spillValid)                fifoWrData <= spillChar;
      else if (strobe.wrHeldThenCur) fifoWrData <= heldChar;
      else if (strobe.wrCur)         fifoWrData <= rxData;
    end
  end

  // Pause state toward the transmitter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pausePending <= 1'b0;
      txHold       <= 1'b0;
      flowFlag     <= 1'b0;
    end else if (strobe.flowOff) begin
      pausePending <= 1'b0;
      txHold       <= 1'b0;
    end else if (strobe.xonHit) begin
      pausePending <= 1'b0;
      txHold       <= 1'b0;
      flowFlag     <= 1'b0;
    end else if (strobe.xoffHit) begin
      flowFlag <= 1'b1;
      if (txBoundary || txHold) txHold <= 1'b1;
      else                      pausePending <= 1'b1;
    end else if (pausePending && txBoundary) begin
      txHold       <= 1'b1;
      pausePending <= 1'b0;
    end
  end

  assign irq = flowFlag && cfgIntEn;

  assert_hold_at_boundary_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txHold) |-> $past(txBoundary));

  assert_stop_sets_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xoffHit |=> flowFlag);

  assert_resume_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xonHit |=> (!txHold && !flowFlag));

  assert_match_dropped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.xoffHit || strobe.xonHit) |=> !fifoWrEn);

  assert_broken_pair_two_writes_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrHeldThenCur |=> (fifoWrEn && spillValid));

  assert_strobe_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    spillValid |-> !rxValid);

  assert_off_releases_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flowOff |=> !txHold);

endmodule

// File: rtl/swFlowMatcher.sv
module swFlowMatcher
  import swfc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic [1:0]        cfgMode,
  input  logic [LEN_W-1:0]  cfgWordLen,
  input  logic [CHAR_W-1:0] cfgXon1,
  input  logic [CHAR_W-1:0] cfgXon2,
  input  logic [CHAR_W-1:0] cfgXoff1,
  input  logic [CHAR_W-1:0] cfgXoff2,
  input  logic              cfgIntEn,
  input  logic              txBoundary,
  output logic              txHold,
  output logic              fifoWrEn,
  output logic [CHAR_W-1:0] fifoWrData,
  output logic              flowFlag,
  output logic              irq
);

  logic [NUM_REF-1:0][CHAR_W-1:0] refChars;
  logic [NUM_REF-1:0]             hit;
  fcStrobe_t                      strobe;

  always_comb begin
    refChars            = '0;
    refChars[IDX_XOFF1] = cfgXoff1;
    refChars[IDX_XOFF2] = cfgXoff2;
    refChars[IDX_XON1]  = cfgXon1;
    refChars[IDX_XON2]  = cfgXon2;
  end

  swfc_cmp #(.CHAR_W(CHAR_W), .NUM_REF(NUM_REF), .LEN_W(LEN_W)) uCmp (
    .rxData   (rxData),
    .refChars (refChars),
    .wordLen  (cfgWordLen),
    .hit      (hit)
  );

  swfc_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxValid  (rxValid),
    .cfgMode  (cfgMode),
    .hitXoff1 (hit[IDX_XOFF1]),
    .hitXoff2 (hit[IDX_XOFF2]),
    .hitXon1  (hit[IDX_XON1]),
    .hitXon2  (hit[IDX_XON2]),
    .strobe   (strobe)
  );

  swfc_dp #(.CHAR_W(CHAR_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .rxValid    (rxValid),
    .rxData     (rxData),
    .txBoundary (txBoundary),
    .cfgIntEn   (cfgIntEn),
    .strobe     (strobe),
    .txHold     (txHold),
    .fifoWrEn   (fifoWrEn),
    .fifoWrData (fifoWrData),
    .flowFlag   (flowFlag),
    .irq        (irq)
  );

endmodule

// File: tb/tb_swFlowMatcher.sv
module tb_swFlowMatcher;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic [1:0] cfgMode = 2'd0;
  logic [1:0] cfgWordLen = 2'd3;
  logic [7:0] cfgXon1 = '0, cfgXon2 = '0, cfgXoff1 = '0, cfgXoff2 = '0;
  logic       cfgIntEn = 1'b0;
  logic       txBoundary = 1'b0;
  logic       txHold, fifoWrEn, flowFlag, irq;
  logic [7:0] fifoWrData;

  int vectors = 0;
  int miscompares = 0;
  bit started = 0;

  swFlowMatcher dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .cfgMode(cfgMode), .cfgWordLen(cfgWordLen),
    .cfgXon1(cfgXon1), .cfgXon2(cfgXon2), .cfgXoff1(cfgXoff1), .cfgXoff2(cfgXoff2),
    .cfgIntEn(cfgIntEn), .txBoundary(txBoundary),
    .txHold(txHold), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .flowFlag(flowFlag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  logic [7:0] mQ[$];
  bit         mHeld, mHeldX, mHeldN;
  logic [7:0] mHeldChar;
  logic [1:0] mPrev;
  bit         mPend, mHold, mFlag, mWr;
  logic [7:0] mData;

  function automatic bit eqm(logic [7:0] a, logic [7:0] b, logic [1:0] wl);
    logic [7:0] m;
    m = 8'((1 << (5 + int'(wl))) - 1);
    return ((a ^ b) & m) == 8'd0;
  endfunction

  always @(posedge clk) begin : model
    bit isOff, doX, doN;
    if (!rstN) begin
      mQ.delete();
      mHeld = 0; mHeldX = 0; mHeldN = 0; mHeldChar = '0; mPrev = 2'd0;
      mPend = 0; mHold = 0; mFlag = 0; mWr = 0; mData = '0;
    end else begin
      isOff = (cfgMode == 2'd0) || (cfgMode == 2'd3);
      if (cfgMode != mPrev) mHeld = 0;   // R10
      mPrev = cfgMode;
      doX = 0; doN = 0;
      if (rxValid) begin
        if (isOff) mQ.push_back(rxData);                       // R2
        else if (cfgMode == 2'd1) begin                        // R3
          if (eqm(rxData, cfgXoff1, cfgWordLen)) doX = 1;
          else if (eqm(rxData, cfgXon1, cfgWordLen)) doN = 1;
          else mQ.push_back(rxData);
        end else begin                                         // R4 R5 R11
          if (mHeld) begin
            if (mHeldX && eqm(rxData, cfgXoff2, cfgWordLen)) doX = 1;
            else if (mHeldN && eqm(rxData, cfgXon2, cfgWordLen)) doN = 1;
            else begin mQ.push_back(mHeldChar); mQ.push_back(rxData); end
            mHeld = 0;
          end else if (eqm(rxData, cfgXoff1, cfgWordLen) || eqm(rxData, cfgXon1, cfgWordLen)) begin
            mHeld = 1; mHeldChar = rxData;
            mHeldX = eqm(rxData, cfgXoff1, cfgWordLen);
            mHeldN = eqm(rxData, cfgXon1, cfgWordLen);
          end else mQ.push_back(rxData);
        end
      end
      if (cfgMode != 2'd2) mHeld = 0;
      if (isOff) begin mPend = 0; mHold = 0; end               // R12
      else if (doN) begin mPend = 0; mHold = 0; mFlag = 0; end  // R7
      else if (doX) begin                                      // R6
        mFlag = 1;
        if (txBoundary || mHold) mHold = 1; else mPend = 1;
      end else if (mPend && txBoundary) begin mHold = 1; mPend = 0; end
      if (mQ.size() > 0) begin mWr = 1; mData = mQ.pop_front(); end
      else mWr = 0;
    end
  end

  // ---------------- comparison ----------------
  task automatic chk(string tag, string sig, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, sig, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (started) begin
      if (!rstN) begin
        chk("R1", "txHold",   {7'd0, txHold},   8'd0);
        chk("R1", "fifoWrEn", {7'd0, fifoWrEn}, 8'd0);
        chk("R1", "flowFlag", {7'd0, flowFlag}, 8'd0);
        chk("R1", "irq",      {7'd0, irq},      8'd0);
      end else begin
        chk("R6 R7 R12", "txHold", {7'd0, txHold}, {7'd0, mHold});
        chk("R2 R3 R4 R5 R9 R10 R11", "fifoWrEn", {7'd0, fifoWrEn}, {7'd0, mWr});
        if (mWr) chk("R2 R5 R9", "fifoWrData", fifoWrData, mData);
        chk("R3 R7", "flowFlag", {7'd0, flowFlag}, {7'd0, mFlag});
        chk("R8", "irq", {7'd0, irq}, {7'd0, mFlag && cfgIntEn});
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendChar(logic [7:0] c);
    @(negedge clk);
    rxValid = 1'b1;
    rxData  = c;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(posedge clk);
    started = 1;
    idle(3);                          // R1 reset state checked each cycle
    rstN = 1'b1;
    idle(2);                          // R1 first cycle after reset
    cfgXoff1 = 8'h13; cfgXoff2 = 8'h14; cfgXon1 = 8'h11; cfgXon2 = 8'h12;

    // R2: both off encodings pass control codes through
    cfgMode = 2'd0;
    sendChar(8'h13); sendChar(8'h41); sendChar(8'h11);
    cfgMode = 2'd3;
    sendChar(8'h13); sendChar(8'h14); idle(2);

    // R3 R6: stop while mid-character, hold waits for boundary
    cfgMode = 2'd1; cfgIntEn = 1'b1; txBoundary = 1'b0;
    idle(1);
    sendChar(8'h13); idle(4);
    txBoundary = 1'b1; idle(2);
    sendChar(8'h55);                  // data while paused
    sendChar(8'h11); idle(2);         // R7 resume
    sendChar(8'h13); idle(2);         // R6 immediate hold at boundary
    cfgIntEn = 1'b0; idle(2);         // R8
    cfgIntEn = 1'b1;
    sendChar(8'h11); idle(2);

    // R7: resume before boundary cancels waiting pause
    txBoundary = 1'b0;
    sendChar(8'h13); idle(2); sendChar(8'h11); txBoundary = 1'b1; idle(3);

    // R9: 5-bit compare makes 0xF3 match stop code, 8-bit does not
    cfgWordLen = 2'd0;
    sendChar(8'hF3); idle(1); sendChar(8'hF1); idle(1);
    cfgWordLen = 2'd3;
    sendChar(8'hF3); sendChar(8'hF1); idle(2);

    // R4 R5: pair mode
    cfgMode = 2'd2; idle(1);
    sendChar(8'h13); sendChar(8'h14); idle(2);
    sendChar(8'h11); sendChar(8'h12); idle(2);
    sendChar(8'h13); sendChar(8'h55); idle(2);
    sendChar(8'h11); sendChar(8'h13); sendChar(8'h14); idle(2);
    sendChar(8'h13); sendChar(8'h13); sendChar(8'h14); idle(2);

    // R11: shared first character resolved by second
    cfgXon1 = 8'h13;
    sendChar(8'h13); sendChar(8'h12); idle(2);
    sendChar(8'h13); sendChar(8'h14); idle(2);
    cfgXon1 = 8'h11;

    // R10: mode change mid-pair drops held character
    sendChar(8'h13); cfgMode = 2'd1; sendChar(8'h66); idle(2);
    cfgMode = 2'd2; idle(1);
    sendChar(8'h11); cfgMode = 2'd0; idle(1); sendChar(8'h77); idle(2);

    // R12: off mode releases the hold but keeps the flag
    cfgMode = 2'd1; txBoundary = 1'b1;
    sendChar(8'h13); idle(2);
    cfgMode = 2'd0; idle(2);
    cfgMode = 2'd1; idle(1);
    sendChar(8'h11); idle(2);

    // Random mix against the model (all requirements)
    for (int n = 0; n < 500; n++) begin
      logic [7:0] c;
      case ($urandom % 6)
        0: c = 8'h13;
        1: c = 8'h14;
        2: c = 8'h11;
        3: c = 8'h12;
        default: c = 8'($urandom);
      endcase
      if ($urandom % 20 == 0) cfgMode = 2'($urandom);
      if ($urandom % 40 == 0) cfgWordLen = 2'($urandom);
      if ($urandom % 4 == 0)  txBoundary = ~txBoundary;
      if ($urandom % 10 == 0) cfgIntEn = ~cfgIntEn;
      sendChar(c);
      idle(int'($urandom % 3));
    end
    idle(4);
    summary();
  end

endmodule